// File: doc/BRIEF.md
# Video Controller Interrupt Register

This block is the 8-bit interrupt register of a video controller. Two timing sources feed it: one pulses once per scan-line event and the other once per second. Each pulse sets a sticky status bit. Software sets two enable bits with a control write. It drops status bits with a clear write, in which a zero bit removes the matching status. The register derives a summary bit from the status and enable fields. That summary bit drives a level interrupt line.

The summary is found by shifting the status pair down four places so that it lines up with the enable pair, then testing whether the two fields overlap. Status latches whatever the enables say. A source that is disabled therefore still records its event, and turning on its enable later raises the interrupt at once. The timing sources themselves are outside this block. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `vid_irq_reg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the register reads 0x00 and the interrupt line is low.
- R2: The register reads as follows:
  - bit 7 is the summary;
  - bit 6 is the one-second status and bit 5 the scan-line status;
  - bit 2 is the one-second enable and bit 1 the scan-line enable;
  - bits 4, 3 and 0 always read 0.
- R3: An event pulse sets its status bit on the next cycle whether its enable is set or clear, and that bit stays set until it is cleared.
- R4: A clear write removes status bit 6 or bit 5 where the written value holds a 0 in that bit. A 1 in the written value leaves that status bit as it was. The enables and all other bits are not touched by a clear write.
- R5: A control write copies bits 2 and 1 of the written value into the enable bits. The status bits and all other bits are not touched by a control write. Without a control write the enables hold their value.
- R6: Bit 7 is set exactly when (bit 6 AND bit 2) OR (bit 5 AND bit 1) is true, and it follows every update in the same cycle.
- R7: The interrupt line always equals bit 7 of the register.
- R8: When an event and a clear write of the same status bit happen in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_evt | input | 1 | Scan-line event pulse, one cycle long |
| sec_evt | input | 1 | One-second event pulse, one cycle long |
| clr_we | input | 1 | Clear-write strobe |
| clr_data | input | 8 | Clear value; a 0 in bit 6 or bit 5 removes that status |
| ctl_we | input | 1 | Control-write strobe |
| ctl_data | input | 8 | Control value; bits 2:1 become the enables |
| rd_data | output | 8 | Current register value |
| irq | output | 1 | Level interrupt line |

## Verification
Two cases are the hardest to reach from the ports:
- An event and a clear write of the same bit in one cycle, on top of a chosen earlier status and enable state.
- A status bit that was latched while its source was disabled and is then enabled.

To reach them, the bench first builds every one of the sixteen starting states. It does this with a reset, then a control write, then pulses on the event pins. From each starting state it applies every combination of the two events, the two strobes and the relevant data bits. The bits of the written values that the block should ignore are also varied.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int REG_W   = 8;
  localparam int SRC_N   = 2;   // index 0: scan line, index 1: one second
  localparam int ST_LSB  = 5;   // status field base
  localparam int EN_LSB  = 1;   // enable field base
  localparam int SUM_BIT = 7;
  localparam int ALIGN   = ST_LSB - EN_LSB;

  typedef logic [SRC_N-1:0] src_vec_t;
  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/vid_irq_status.sv
module vid_irq_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_keep,
  output logic [N-1:0] st
);
  // One sticky bit per source; a set request outranks a clear
  for (genvar g = 0; g < N; g++) begin : g_src
    logic drop;
    assign drop = clr_we & ~clr_keep[g];
    always_ff @(posedge clk) begin
      if (!rst_n)      st[g] <= 1'b0;
      else if (evt[g]) st[g] <= 1'b1;
      else if (drop)   st[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_irq_enable.sv
module vid_irq_enable #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [N-1:0] ctl_field,
  output logic [N-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (ctl_we) en <= ctl_field;
  end
endmodule

// File: rtl/vid_irq_summary.sv
module vid_irq_summary #(
  parameter int W     = 8,
  parameter int SHIFT = 4,
  parameter int LSB   = 1,
  parameter int N     = 2
) (
  input  logic [W-1:0] word,
  output logic         sum
);
  localparam logic [W-1:0] MASK = ((W'(1) << N) - W'(1)) << LSB;
  logic [W-1:0] aligned;
  assign aligned = (word >> SHIFT) & MASK;
  assign sum     = |(aligned & word);
endmodule

// File: rtl/vid_irq_reg.sv
module vid_irq_reg
  import vid_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_evt,
  input  logic             sec_evt,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_data,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  src_vec_t  st, en;
  reg_word_t base_word;
  logic      sum;

  vid_irq_status #(.N(SRC_N)) u_status (
    .clk(clk), .rst_n(rst_n),
    .evt({sec_evt, line_evt}),
    .clr_we(clr_we),
    .clr_keep(clr_data[ST_LSB +: SRC_N]),
    .st(st)
  );

  vid_irq_enable #(.N(SRC_N)) u_enable (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we),
    .ctl_field(ctl_data[EN_LSB +: SRC_N]),
    .en(en)
  );

  always_comb begin
    base_word = '0;
    base_word[ST_LSB +: SRC_N] = st;
    base_word[EN_LSB +: SRC_N] = en;
  end

  vid_irq_summary #(.W(REG_W), .SHIFT(ALIGN), .LSB(EN_LSB), .N(SRC_N)) u_sum (
    .word(base_word),
    .sum(sum)
  );

  always_comb begin
    rd_data = base_word;
    rd_data[SUM_BIT] = sum;
  end
  assign irq = sum;
endmodule

// File: rtl/vid_irq_reg_chk.sv
module vid_irq_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_evt,
  input logic       sec_evt,
  input logic       clr_we,
  input logic [7:0] clr_data,
  input logic       ctl_we,
  input logic [7:0] ctl_data,
  input logic [7:0] rd_data,
  input logic       irq
);
  // R7
  irq_tracks_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == rd_data[7]);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:3] == 2'b00 && rd_data[0] == 1'b0);
  // R3
  line_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt |=> rd_data[5]);
  // R3
  sec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> rd_data[6]);
  // R4
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !clr_data[6] && !sec_evt) |=> !rd_data[6]);
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(rd_data[2:1]));
  // R5
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> rd_data[2:1] == $past(ctl_data[2:1]));
  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && clr_we && !clr_data[5]) |=> rd_data[5]);
endmodule

bind vid_irq_reg vid_irq_reg_chk u_chk (.*);

// File: tb/test_vid_irq_reg.sv
`timescale 1ns/1ps
module test_vid_irq_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_evt, sec_evt, clr_we, ctl_we;
  logic [7:0] clr_data, ctl_data;
  logic [7:0] rd_data;
  logic       irq;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vid_irq_reg i_vid_irq_reg (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    line_evt = 0; sec_evt = 0; clr_we = 0; ctl_we = 0;
    clr_data = 8'h00; ctl_data = 8'h00;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // Bring the register to status st (bit1 = one-second, bit0 = scan-line) and enables en
  task automatic preset(input logic [1:0] st, input logic [1:0] en);
    @(negedge clk); idle(); rst_n = 0;
    cyc();
    @(negedge clk); rst_n = 1; ctl_we = 1; ctl_data = {5'b0, en, 1'b0};
    cyc();
    @(negedge clk); idle(); sec_evt = st[1]; line_evt = st[0];
    cyc();
    @(negedge clk); idle();
  endtask

  function automatic logic [7:0] word(input logic [1:0] st, input logic [1:0] en);
    return {|(st & en), st, 2'b00, en, 1'b0};
  endfunction

  initial begin
    idle();
    rst_n = 0;
    cyc(); cyc();
    // R1: reset value and low interrupt line
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    cyc();
    chk("R1", rd_data, 8'h00);

    // R3: latched while disabled, then enabling raises the summary (R6)
    @(negedge clk); line_evt = 1;
    cyc();
    @(negedge clk); idle();
    chk("R3", rd_data, 8'h20);
    @(negedge clk); ctl_we = 1; ctl_data = 8'h02;
    cyc();
    @(negedge clk); idle();
    chk("R6", rd_data, 8'hA2);

    // Exhaustive sweep: 16 start states x 128 input combinations
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 128; v++) begin
        logic [1:0] st0, en0, ev, ck, cn, st1, en1, hit;
        logic       cw, nw;
        logic [7:0] exp, junk;
        st0 = s[3:2]; en0 = s[1:0];
        ev = v[1:0]; cw = v[2]; ck = v[4:3]; nw = v[5]; cn = {v[6], ~v[6] ^ v[0]};
        junk = 8'(v * 37 + s * 11);
        preset(st0, en0);
        chk("R2", rd_data, word(st0, en0));
        line_evt = ev[0]; sec_evt = ev[1];
        clr_we = cw; clr_data = {junk[7], ck[1], ck[0], junk[4:0]};
        ctl_we = nw; ctl_data = {junk[7:3], cn[1], cn[0], junk[0]};
        cyc();
        hit = {2{cw}} & ~ck;
        st1 = (st0 & ~hit) | ev;
        en1 = nw ? cn : en0;
        exp = word(st1, en1);
        if ((ev & hit) != 2'b00)  chk("R8", {6'b0, rd_data[6:5]}, {6'b0, st1});
        else if (cw)              chk("R4", {6'b0, rd_data[6:5]}, {6'b0, st1});
        else                      chk("R3", {6'b0, rd_data[6:5]}, {6'b0, st1});
        chk("R5", {6'b0, rd_data[2:1]}, {6'b0, en1});
        chk("R6", {7'b0, rd_data[7]}, {7'b0, exp[7]});
        chk("R7", {7'b0, irq}, {7'b0, exp[7]});
        chk("R2", {5'b0, rd_data[4:3], rd_data[0]}, 8'h00);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule